// File: doc/BRIEF.md
# Three-Wire Serial Word EEPROM Device Model

This block is a synthesizable model of the device side of a three-wire serial EEPROM that holds 64 words of 16 bits. It runs on a fast system clock and passes chip select, serial clock and serial data-in through synchronisers. Edges of the serial clock and of chip select are then detected inside the system-clock domain. A host frames each command with chip select. It clocks in a start bit, a 2-bit opcode, a 6-bit word address and, where the command needs one, a 16-bit data word.

Reads return data on a serial output that has its own output-enable. Programming commands are held until chip select falls, and they are carried out only while the write-enable latch is set. Each programming command is followed by a busy period whose length is a parameter counted in system clocks. While chip select is high during and after that period, the serial output reports busy or ready.

Top module: `mw_eeprom`

## Requirements
- R1: After reset every word reads 0xFFFF, the write-enable latch is clear, and `do_oe_o` stays low until a command drives the output.
- R2: Zeros sampled on serial-clock rising edges while chip select is high are skipped until the first 1, which is taken as the start bit.
- R3: Read (opcode 2'b10, after the start bit) enables the output. The first bit on `do_o` is a dummy 0, followed by the addressed word MSB first. Each bit appears after a serial-clock rising edge, and a read works with the write-enable latch set or clear.
- R4: Write (opcode 2'b01) takes 16 data bits MSB first and stores them at the 6-bit address, sent MSB first. The store happens when chip select falls.
- R5: Erase (opcode 2'b11) sets the addressed word to 0xFFFF and leaves every other word unchanged.
- R6: Opcode 2'b00 with address bits [5:4] = 2'b11 sets the write-enable latch, and with 2'b00 clears it. A programming command given while the latch is clear changes no word and starts no busy period.
- R7: Opcode 2'b00 with address bits [5:4] = 2'b10 sets every word to 0xFFFF.
- R8: Opcode 2'b00 with address bits [5:4] = 2'b01 takes 16 data bits and stores them in every word.
- R9: After a programming command starts, `do_o` reads 0 while chip select is high and the PROG_CYCLES busy period runs, and 1 once it ends. `do_oe_o` is low whenever chip select is low.
- R10: Commands clocked in while the busy period runs are ignored.
- R11: Taking chip select low before a command is complete discards it, and the next chip-select-high period starts a fresh command.
- R12: The ready/busy display ends when the next start bit is accepted, and a read can follow in the same chip-select period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out or ready/busy |
| do_oe_o | output | 1 | Output enable for do_o |

## Verification
Every one of the 64 addresses is written with an address-dependent pattern and read back. This exposes address decode faults, stuck data bits and bit-order errors that a single word would hide. Fill patterns from write-all and erase-all are read back across the whole array to tell single-word programming apart from whole-array programming. Erase is checked on a word with two written neighbours, and a write is cut short partway through. Commands are given with the enable latch clear and during the busy period, and each should leave the stored data untouched. Leading zeros, the dummy bit and the ready/busy level on the output are each sampled at fixed serial-clock phases.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_DATA, ST_PEND, ST_READ, ST_HOLD
  } fe_state_e;

  typedef enum logic [1:0] {
    PK_WRITE, PK_ERASE, PK_ERAL, PK_WRALL
  } prog_kind_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] EX_WDIS  = 2'b00;
  localparam logic [1:0] EX_WRALL = 2'b01;
  localparam logic [1:0] EX_ERAL  = 2'b10;
  localparam logic [1:0] EX_WEN   = 2'b11;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_one_i,
  input  logic          we_all_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0][DW-1:0] rows;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '1;
      else if (we_all_i || (we_one_i && waddr_i == AW'(w))) word_q <= wdata_i;
    end
    assign rows[w] = word_q;
  end

  assign rdata_o = rows[raddr_i];

  AST_ONE_WRITE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_one_i && we_all_i)); // R4
endmodule

// File: rtl/mw_prog_ctl.sv
module mw_prog_ctl #(
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic start_i,
  output logic busy_o,
  output logic show_o
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q, show_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      show_q <= 1'b0;
    end else begin
      if (go_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(PROG_CYCLES - 1);
      end else if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else cnt_q <= cnt_q - 1'b1;
      end
      if (go_i) show_q <= 1'b1;
      else if (start_i) show_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign show_o = show_q;

  AST_GO_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !busy_q); // R10
  AST_BUSY_FROM_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(go_i)); // R9
endmodule

// File: rtl/mw_cmd_fe.sv
module mw_cmd_fe
  import mw_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          sk_i,
  input  logic          di_i,
  input  logic          busy_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic          start_o,
  output logic          go_o,
  output prog_kind_e    kind_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          rd_active_o,
  output logic          rd_do_o
);
  localparam int HDR_W = 2 + AW;
  localparam int MAXB  = (DW > HDR_W) ? DW : HDR_W;
  localparam int CNT_W = $clog2(MAXB + 1);

  fe_state_e        state_q;
  prog_kind_e       kind_q;
  logic [CNT_W-1:0] cnt_q;
  logic [HDR_W-2:0] hdr_q;
  logic [HDR_W-1:0] hdr_full;
  logic [DW-1:0]    data_q, rsh_q;
  logic [AW-1:0]    addr_q;
  logic [1:0]       op, ext;
  logic             sk_q, cs_q, do_q, wen_q;
  logic             sk_rise, cs_fall;

  assign sk_rise  = cs_i && sk_i && !sk_q;
  assign cs_fall  = !cs_i && cs_q;
  assign hdr_full = {hdr_q, di_i};
  assign op       = hdr_full[HDR_W-1 -: 2];
  assign raddr_o  = hdr_full[AW-1:0];
  assign ext      = raddr_o[AW-1 -: 2];
  assign start_o  = sk_rise && (state_q == ST_IDLE) && di_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= PK_WRITE;
      cnt_q   <= '0;
      hdr_q   <= '0;
      data_q  <= '0;
      rsh_q   <= '0;
      addr_q  <= '0;
      sk_q    <= 1'b0;
      cs_q    <= 1'b0;
      do_q    <= 1'b0;
      wen_q   <= 1'b0;
    end else begin
      sk_q <= sk_i;
      cs_q <= cs_i;
      if (!cs_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        do_q    <= 1'b0;
      end else if (sk_rise) begin
        unique case (state_q)
          ST_IDLE: if (start_o) begin
            state_q <= ST_HDR;
            cnt_q   <= '0;
          end
          ST_HDR: begin
            hdr_q <= hdr_full[HDR_W-2:0];
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(HDR_W - 1)) begin
              addr_q <= raddr_o;
              cnt_q  <= '0;
              unique case (op)
                OP_READ: begin
                  rsh_q   <= rdata_i;
                  do_q    <= 1'b0;
                  state_q <= ST_READ;
                end
                OP_WRITE: begin
                  kind_q  <= PK_WRITE;
                  state_q <= ST_DATA;
                end
                OP_ERASE: begin
                  kind_q  <= PK_ERASE;
                  state_q <= ST_PEND;
                end
                default: begin
                  unique case (ext)
                    EX_WEN:   begin wen_q <= 1'b1; state_q <= ST_HOLD; end
                    EX_WDIS:  begin wen_q <= 1'b0; state_q <= ST_HOLD; end
                    EX_ERAL:  begin kind_q <= PK_ERAL; state_q <= ST_PEND; end
                    default:  begin kind_q <= PK_WRALL; state_q <= ST_DATA; end
                  endcase
                end
              endcase
            end
          end
          ST_DATA: begin
            data_q <= {data_q[DW-2:0], di_i};
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(DW - 1)) state_q <= ST_PEND;
          end
          ST_READ: begin
            do_q  <= rsh_q[DW-1];
            rsh_q <= {rsh_q[DW-2:0], 1'b0};
          end
          default: ;
        endcase
      end
    end
  end

  assign go_o        = cs_fall && (state_q == ST_PEND) && wen_q;
  assign kind_o      = kind_q;
  assign addr_o      = addr_q;
  assign data_o      = data_q;
  assign rd_active_o = (state_q == ST_READ);
  assign rd_do_o     = do_q;

  AST_IDLE_AFTER_CS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cs_i) |-> state_q == ST_IDLE); // R11
  AST_READ_DO_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READ && $past(state_q == ST_READ) && !$past(sk_rise)) |-> $stable(do_q)); // R3
  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(state_q == ST_IDLE)) |-> state_q == ST_IDLE); // R10
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  logic [2:0]    pins_s;
  logic          cs_s, sk_s, di_s;
  logic          busy, show, start, go, rd_active, rd_do;
  prog_kind_e    kind;
  logic [AW-1:0] raddr, paddr;
  logic [DW-1:0] rdata, pdata, wdata;
  logic          we_one, we_all;

  mw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({cs_i, sk_i, di_i}), .q_o(pins_s)
  );
  assign {cs_s, sk_s, di_s} = pins_s;

  mw_cmd_fe #(.AW(AW), .DW(DW)) u_fe (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_s), .sk_i(sk_s), .di_i(di_s),
    .busy_i(busy), .rdata_i(rdata), .raddr_o(raddr), .start_o(start),
    .go_o(go), .kind_o(kind), .addr_o(paddr), .data_o(pdata),
    .rd_active_o(rd_active), .rd_do_o(rd_do)
  );

  mw_prog_ctl #(.PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go), .start_i(start),
    .busy_o(busy), .show_o(show)
  );

  assign we_one = go && (kind == PK_WRITE || kind == PK_ERASE);
  assign we_all = go && (kind == PK_WRALL || kind == PK_ERAL);
  assign wdata  = (kind == PK_ERASE || kind == PK_ERAL) ? '1 : pdata;

  mw_word_array #(.AW(AW), .DW(DW)) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_one_i(we_one), .we_all_i(we_all),
    .waddr_i(paddr), .wdata_i(wdata), .raddr_i(raddr), .rdata_o(rdata)
  );

  assign do_o    = rd_active ? rd_do : !busy;
  assign do_oe_o = cs_s && (rd_active || show);

  AST_READ_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_active |-> !busy); // R10
  AST_OE_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cs_i) && !cs_s |-> !do_oe_o); // R9
endmodule

// File: tb/mw_eeprom_test.sv
module mw_eeprom_test;
  localparam int PROG = 400;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_w, oe_w;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  mw_eeprom #(.PROG_CYCLES(PROG)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_w), .do_oe_o(oe_w)
  );

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 16'h0A53) ^ 16'h3C96);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sk = 1'b0; di = b; tick(HALF);
    sk = 1'b1; tick(HALF);
  endtask

  task automatic cs_up();
    sk = 1'b0; cs = 1'b1; tick(4);
  endtask

  task automatic cs_down();
    sk = 1'b0; tick(2); cs = 1'b0; tick(4);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d,
                          input int nd, input int lead);
    for (int i = 0; i < lead; i++) bit_out(1'b0);
    bit_out(1'b1);
    bit_out(op[1]); bit_out(op[0]);
    for (int i = 5; i >= 0; i--) bit_out(a[i]);
    for (int i = 0; i < nd; i++) bit_out(d[15-i]);
  endtask

  task automatic prog(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d, input int nd);
    cs_up(); send_cmd(op, a, d, nd, 0); cs_down(); tick(PROG + 20);
  endtask

  task automatic rd_body(input logic [5:0] a, input int lead, output logic [15:0] v, output logic dum_ok);
    send_cmd(2'b10, a, 16'h0, 0, lead);
    dum_ok = (do_w === 1'b0) && (oe_w === 1'b1);
    for (int i = 15; i >= 0; i--) begin
      bit_out(1'b0);
      v[i] = do_w;
    end
  endtask

  task automatic chk_read(input logic [5:0] a, input logic [15:0] exp, input string req);
    logic [15:0] v;
    logic dok;
    cs_up(); rd_body(a, 0, v, dok); cs_down();
    chk(dok && v === exp, req, {15'd0, dok, v}, {16'h1, exp});
  endtask

  task automatic sweep(input int mode, input logic [15:0] k, input string req);
    int bad = 0;
    logic [15:0] v, e;
    logic dok;
    for (int a = 0; a < 64; a++) begin
      e = (mode == 0) ? pat(a) : k;
      cs_up(); rd_body(6'(a), 0, v, dok); cs_down();
      if (!(dok && v === e)) begin
        bad++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, v, e);
      end
    end
    checks++;
    if (bad != 0) fails++;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic dok;
    tick(5); rst_n = 1'b1; tick(5);

    // R1: reset state
    chk(oe_w === 1'b0, "R1 oe idle", {31'd0, oe_w}, 0);
    cs_up(); tick(10);
    chk(oe_w === 1'b0, "R1 oe cs high no cmd", {31'd0, oe_w}, 0);
    cs_down();
    chk_read(6'd0, 16'hFFFF, "R1 word0");
    chk_read(6'd63, 16'hFFFF, "R1 word63");

    // R6: write while disabled -> no change, no busy
    cs_up(); send_cmd(2'b01, 6'd5, 16'h1111, 16, 0); cs_down();
    cs_up(); tick(20);
    chk(oe_w === 1'b0, "R6 no busy when disabled", {31'd0, oe_w}, 0);
    cs_down(); tick(PROG);
    chk_read(6'd5, 16'hFFFF, "R6 disabled write");

    // R6: enable
    prog(2'b00, 6'b110000, 16'h0, 0);

    // R2 + R4 + R9: write with leading zeros, watch busy/ready
    cs_up(); send_cmd(2'b01, 6'd9, 16'h1234, 16, 3); cs_down();
    chk(oe_w === 1'b0, "R9 oe low cs low", {31'd0, oe_w}, 0);
    cs = 1'b1; tick(20);
    chk(oe_w === 1'b1 && do_w === 1'b0, "R9 busy", {30'd0, oe_w, do_w}, 2);
    tick(PROG);
    chk(oe_w === 1'b1 && do_w === 1'b1, "R9 ready", {30'd0, oe_w, do_w}, 3);
    cs_down();
    chk(oe_w === 1'b0, "R9 oe released", {31'd0, oe_w}, 0);
    chk_read(6'd9, 16'h1234, "R2 R4 lead zeros write");
    cs_up(); rd_body(6'd9, 5, v, dok); cs_down();
    chk(dok && v === 16'h1234, "R2 read lead zeros", {15'd0, dok, v}, {16'h1, 16'h1234});

    // R10: command during busy ignored
    cs_up(); send_cmd(2'b01, 6'd11, 16'hAAAA, 16, 0); cs_down();
    cs_up(); send_cmd(2'b01, 6'd12, 16'h5555, 16, 0); cs_down();
    tick(PROG + 20);
    chk_read(6'd11, 16'hAAAA, "R4 first write");
    chk_read(6'd12, 16'hFFFF, "R10 busy ignore");

    // R3 R4: exhaustive address sweep
    for (int a = 0; a < 64; a++) prog(2'b01, 6'(a), pat(a), 16);
    sweep(0, 16'h0, "R4 R3 sweep");

    // R5: erase one word, neighbours untouched
    prog(2'b11, 6'd20, 16'h0, 0);
    chk_read(6'd20, 16'hFFFF, "R5 erase");
    chk_read(6'd19, pat(19), "R5 neighbour low");
    chk_read(6'd21, pat(21), "R5 neighbour high");

    // R11: aborted write, fresh command after
    cs_up(); send_cmd(2'b01, 6'd30, 16'h0000, 8, 0); cs_down(); tick(PROG + 20);
    chk_read(6'd30, pat(30), "R11 abort");

    // R6: disable, erase ignored; R3: read works disabled
    prog(2'b00, 6'b000000, 16'h0, 0);
    cs_up(); send_cmd(2'b11, 6'd31, 16'h0, 0, 0); cs_down();
    cs_up(); tick(20);
    chk(oe_w === 1'b0, "R6 erase disabled no busy", {31'd0, oe_w}, 0);
    cs_down(); tick(PROG);
    chk_read(6'd31, pat(31), "R6 R3 disabled erase/read");

    // R8: write all
    prog(2'b00, 6'b110000, 16'h0, 0);
    prog(2'b00, 6'b010000, 16'hC3A5, 16);
    sweep(1, 16'hC3A5, "R8 write all");

    // R7 + R12: erase all, ready then read in same CS period
    cs_up(); send_cmd(2'b00, 6'b100101, 16'h0, 0, 0); cs_down();
    tick(PROG + 20);
    cs_up();
    chk(oe_w === 1'b1 && do_w === 1'b1, "R12 ready shown", {30'd0, oe_w, do_w}, 3);
    rd_body(6'd7, 0, v, dok);
    cs_down();
    chk(dok && v === 16'hFFFF, "R12 read after status", {15'd0, dok, v}, {16'h1, 16'hFFFF});
    sweep(1, 16'hFFFF, "R7 erase all");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule